// File: doc/BRIEF.md
# Packed Halfword Unsigned Adder

This execution unit serves a 32-bit DSP extension. Each cycle it may accept one instruction word together with the two 32-bit operand values that the register file supplies. It treats each operand as two unsigned 16-bit lanes and adds matching lanes on their own. One encoding bit chooses the arithmetic. In the wrapping form, each lane keeps its sum modulo 65536. In the saturating form, a lane that would pass 65535 is pinned to 0xFFFF. The unit returns the packed 32-bit result and the destination register index one cycle after the word is accepted.

Any lane carry sets a sticky overflow bit at position 20 of a DSP control word, whichever form is used. That bit stays set until a clear request arrives on the control port. The unit reports two faults. A word that does not match the expected encoding raises a reserved-instruction fault. A matching word issued while the DSP resources are switched off raises a DSP-disabled fault. When a fault is raised, no result is produced and the control word is left as it was. Operand values never cause a fault.

A small state machine holds the outcome of the previous cycle. ST_IDLE means no word was presented. ST_DONE means a result is valid. ST_TRAP_RSV means the encoding was not recognised. ST_TRAP_OFF means the DSP was disabled. Every state is entered straight from any state on the current inputs. A clock edge with in_valid low goes to ST_IDLE. A word that does not match goes to ST_TRAP_RSV. A matching word with dsp_en low goes to ST_TRAP_OFF. A matching word with dsp_en high goes to ST_DONE.

Top module: `halfword_add_unit`

## Requirements
- R1: A word is recognised only when bits 31:26 equal 001000, bits 9:3 equal 0100001 and bits 2:0 equal 101. Bits 15:11 of an accepted word appear on out_dest.
- R2: When bit 10 is 0 (wrapping form), out_result[31:16] is (src_s[31:16] + src_t[31:16]) mod 65536 and out_result[15:0] is (src_s[15:0] + src_t[15:0]) mod 65536. No carry crosses between lanes.
- R3: When bit 10 is 1 (saturating form), any lane whose true sum exceeds 65535 reads 0xFFFF. Every other lane reads its exact sum.
- R4: In either form, an accepted word with a carry out of either lane sets bit 20 of ctl_rd_data. All other bits of ctl_rd_data always read 0.
- R5: Bit 20 is sticky. An accepted add without carry leaves it set. A ctl_clear pulse with no carry in the same cycle clears it. If a carry and ctl_clear fall in the same cycle, the bit ends set.
- R6: An unrecognised word with in_valid raises exc_reserved for one cycle. It gives no out_valid, and out_result, out_dest and ctl_rd_data do not change.
- R7: A recognised word with in_valid while dsp_en is 0 raises exc_disabled for one cycle, with the same no-effect rules as R6. When the word is also unrecognised, only exc_reserved is raised.
- R8: out_valid pulses for exactly one cycle, in the cycle after each accepted word. out_result and out_dest hold their last values until the next accepted word.
- R9: After reset, out_valid, exc_reserved, exc_disabled, out_result, out_dest and ctl_rd_data are all 0.
- R10: src_s_idx shows bits 20:16 and src_t_idx shows bits 25:21 of in_word, combinationally, so the register file can fetch the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction word is presented |
| in_word | input | 32 | Instruction word |
| src_s | input | 32 | First operand value (register selected by src_s_idx) |
| src_t | input | 32 | Second operand value (register selected by src_t_idx) |
| dsp_en | input | 1 | DSP resources enabled |
| ctl_clear | input | 1 | Clear request for the sticky overflow bit |
| src_s_idx | output | 5 | First source register index |
| src_t_idx | output | 5 | Second source register index |
| out_valid | output | 1 | Result valid pulse |
| out_result | output | 32 | Packed two-lane result |
| out_dest | output | 5 | Destination register index |
| exc_reserved | output | 1 | Reserved-instruction fault pulse |
| exc_disabled | output | 1 | DSP-disabled fault pulse |
| ctl_rd_data | output | 32 | DSP control word (overflow bit at position 20) |

## Verification
Two functions can meet in one cycle: a software clear of the sticky overflow bit, and an accepted add whose lane carry sets that same bit. The bench provokes this meeting by driving ctl_clear in the same cycle as an overflowing word. It expects the bit to read 1 afterwards. It then repeats the clear against a word that does not overflow and expects 0. It also pairs a clear with a faulting word, where the clear must still take effect while the fault leaves everything else unchanged.

// File: rtl/hwadd_pkg.sv
package hwadd_pkg;

    localparam int IDX_W = 5;

    localparam logic [5:0] MAJOR_CODE = 6'b001000;
    localparam logic [6:0] MINOR_CODE = 7'b0100001;
    localparam logic [2:0] TAIL_CODE  = 3'b101;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DONE,
        ST_TRAP_RSV,
        ST_TRAP_OFF
    } state_e;

    typedef struct packed {
        logic             match;
        logic             sat;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rs;
        logic [IDX_W-1:0] rt;
    } dec_t;

endpackage

// File: rtl/hwadd_decode.sv
module hwadd_decode
    import hwadd_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);

    logic major_ok;
    logic minor_ok;
    logic tail_ok;

    always_comb begin
        major_ok  = (word[31:26] == MAJOR_CODE);
        minor_ok  = (word[9:3]   == MINOR_CODE);
        tail_ok   = (word[2:0]   == TAIL_CODE);
        dec.match = major_ok && minor_ok && tail_ok;
        dec.sat   = word[10];
        dec.rt    = word[25:21];
        dec.rs    = word[20:16];
        dec.rd    = word[15:11];
    end

endmodule

// File: rtl/hwadd_lane.sv
module hwadd_lane #(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] op_a,
    input  logic [LANE_W-1:0] op_b,
    input  logic              sat,
    output logic [LANE_W-1:0] sum,
    output logic              carry
);

    logic [LANE_W:0] wide;

    always_comb begin
        wide  = {1'b0, op_a} + {1'b0, op_b};
        carry = wide[LANE_W];
        if (sat && carry) begin
            sum = '1;
        end else begin
            sum = wide[LANE_W-1:0];
        end
    end

endmodule

// File: rtl/hwadd_flag.sv
module hwadd_flag #(
    parameter int DATA_W   = 32,
    parameter int FLAG_POS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic              clr,
    output logic [DATA_W-1:0] ctl_word
);

    logic ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (set) begin
            ovf_q <= 1'b1;
        end else if (clr) begin
            ovf_q <= 1'b0;
        end
    end

    always_comb begin
        ctl_word           = '0;
        ctl_word[FLAG_POS] = ovf_q;
    end

endmodule

// File: rtl/halfword_add_unit.sv
module halfword_add_unit
    import hwadd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LANE_W   = 16,
    parameter int FLAG_POS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_word,
    input  logic [DATA_W-1:0] src_s,
    input  logic [DATA_W-1:0] src_t,
    input  logic              dsp_en,
    input  logic              ctl_clear,
    output logic [IDX_W-1:0]  src_s_idx,
    output logic [IDX_W-1:0]  src_t_idx,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [IDX_W-1:0]  out_dest,
    output logic              exc_reserved,
    output logic              exc_disabled,
    output logic [DATA_W-1:0] ctl_rd_data
);

    localparam int LANES = DATA_W / LANE_W;

    dec_t              dec;
    state_e            state_q;
    state_e            state_d;
    logic [DATA_W-1:0] sum_all;
    logic [LANES-1:0]  lane_carry;
    logic              accept;
    logic              ovf_set;
    logic [DATA_W-1:0] result_q;
    logic [IDX_W-1:0]  dest_q;

    hwadd_decode u_decode (
        .word (in_word),
        .dec  (dec)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hwadd_lane #(.LANE_W(LANE_W)) u_lane (
            .op_a  (src_s[g*LANE_W +: LANE_W]),
            .op_b  (src_t[g*LANE_W +: LANE_W]),
            .sat   (dec.sat),
            .sum   (sum_all[g*LANE_W +: LANE_W]),
            .carry (lane_carry[g])
        );
    end

    always_comb begin
        accept  = in_valid && dec.match && dsp_en;
        ovf_set = accept && (|lane_carry);
    end

    hwadd_flag #(.DATA_W(DATA_W), .FLAG_POS(FLAG_POS)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (ovf_set),
        .clr      (ctl_clear),
        .ctl_word (ctl_rd_data)
    );

    // Next-state choice: depends only on this cycle's word.
    always_comb begin
        state_d = ST_IDLE;
        if (in_valid) begin
            if (!dec.match) begin
                state_d = ST_TRAP_RSV;
            end else if (!dsp_en) begin
                state_d = ST_TRAP_OFF;
            end else begin
                state_d = ST_DONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            dest_q   <= '0;
        end else if (accept) begin
            result_q <= sum_all;
            dest_q   <= dec.rd;
        end
    end

    always_comb begin
        out_valid    = 1'b0;
        exc_reserved = 1'b0;
        exc_disabled = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_DONE:     out_valid    = 1'b1;
            ST_TRAP_RSV: exc_reserved = 1'b1;
            ST_TRAP_OFF: exc_disabled = 1'b1;
            default:     ;
        endcase
    end

    always_comb begin
        out_result = result_q;
        out_dest   = dest_q;
        src_s_idx  = dec.rs;
        src_t_idx  = dec.rt;
    end

endmodule

module hwadd_check #(
    parameter int DATA_W   = 32,
    parameter int FLAG_POS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              dsp_en,
    input logic              ctl_clear,
    input logic              out_valid,
    input logic              exc_reserved,
    input logic              exc_disabled,
    input logic [DATA_W-1:0] ctl_rd_data
);

    // R8
    valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R6
    outcome_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, exc_reserved, exc_disabled}));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd_data[FLAG_POS] && !ctl_clear) |=> ctl_rd_data[FLAG_POS]);

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_clear && !in_valid) |=> !ctl_rd_data[FLAG_POS]);

    // R7
    disabled_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dsp_en) |=> !out_valid);

    // R7
    disabled_ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dsp_en && !ctl_clear) |=> $stable(ctl_rd_data));

endmodule

bind halfword_add_unit hwadd_check #(.DATA_W(DATA_W), .FLAG_POS(FLAG_POS)) u_hwadd_check (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .dsp_en       (dsp_en),
    .ctl_clear    (ctl_clear),
    .out_valid    (out_valid),
    .exc_reserved (exc_reserved),
    .exc_disabled (exc_disabled),
    .ctl_rd_data  (ctl_rd_data)
);

// File: tb/test_halfword_add_unit.sv
module test_halfword_add_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_word;
    logic [31:0] src_s;
    logic [31:0] src_t;
    logic        dsp_en;
    logic        ctl_clear;
    logic [4:0]  src_s_idx;
    logic [4:0]  src_t_idx;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  out_dest;
    logic        exc_reserved;
    logic        exc_disabled;
    logic [31:0] ctl_rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    halfword_add_unit i_halfword_add_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_word      (in_word),
        .src_s        (src_s),
        .src_t        (src_t),
        .dsp_en       (dsp_en),
        .ctl_clear    (ctl_clear),
        .src_s_idx    (src_s_idx),
        .src_t_idx    (src_t_idx),
        .out_valid    (out_valid),
        .out_result   (out_result),
        .out_dest     (out_dest),
        .exc_reserved (exc_reserved),
        .exc_disabled (exc_disabled),
        .ctl_rd_data  (ctl_rd_data)
    );

    function automatic logic [31:0] enc(input logic [4:0] rt, input logic [4:0] rs,
                                        input logic [4:0] rd, input logic sat);
        return {6'b001000, rt, rs, rd, sat, 7'b0100001, 3'b101};
    endfunction

    function automatic logic [15:0] exp_lane(input logic [15:0] a, input logic [15:0] b,
                                             input logic sat);
        int unsigned t;
        t = int'(a) + int'(b);
        if (t > 65535) return sat ? 16'hFFFF : 16'(t - 65536);
        return 16'(t);
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] expv);
        check(act == expv, req, act, expv);
    endtask

    // Present one word for one cycle; sample just after the capturing edge.
    task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                         input logic en, input logic clr);
        @(negedge clk);
        in_valid  = 1'b1;
        in_word   = w;
        src_s     = a;
        src_t     = b;
        dsp_en    = en;
        ctl_clear = clr;
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid  = 1'b0;
        ctl_clear = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        ctl_clear = 1'b1;
        @(negedge clk);
        ctl_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R9 out_valid", {31'd0, out_valid}, 32'd0);
        chk_eq("R9 exc", {30'd0, exc_reserved, exc_disabled}, 32'd0);
        chk_eq("R9 result", out_result, 32'd0);
        chk_eq("R9 dest", {27'd0, out_dest}, 32'd0);
        chk_eq("R9 ctl", ctl_rd_data, 32'd0);
    endtask

    task automatic t_selects();
        @(negedge clk);
        in_word = enc(5'd19, 5'd6, 5'd2, 1'b0);
        #1;
        chk_eq("R10 rs idx", {27'd0, src_s_idx}, 32'd6);
        chk_eq("R10 rt idx", {27'd0, src_t_idx}, 32'd19);
    endtask

    task automatic t_wrap();
        logic [31:0] a;
        logic [31:0] b;
        a = 32'h1234_FFFF;
        b = 32'h1111_0001;
        issue(enc(5'd1, 5'd2, 5'd7, 1'b0), a, b, 1'b1, 1'b0);
        chk_eq("R2 wrap low carry", out_result,
               {exp_lane(a[31:16], b[31:16], 1'b0), exp_lane(a[15:0], b[15:0], 1'b0)});
        chk_eq("R1 dest", {27'd0, out_dest}, 32'd7);
        chk_eq("R8 valid", {31'd0, out_valid}, 32'd1);
        chk_eq("R4 flag wrap", ctl_rd_data, 32'h0010_0000);
        clear_flag();
        a = 32'hF000_0100;
        b = 32'h2000_0200;
        issue(enc(5'd3, 5'd4, 5'd30, 1'b0), a, b, 1'b1, 1'b0);
        chk_eq("R2 wrap high carry", out_result, 32'h1000_0300);
        chk_eq("R4 flag high lane", ctl_rd_data, 32'h0010_0000);
        clear_flag();
        issue(enc(5'd3, 5'd4, 5'd9, 1'b0), 32'h7FFF_8000, 32'h8000_7FFF, 1'b1, 1'b0);
        chk_eq("R2 no carry", out_result, 32'hFFFF_FFFF);
        chk_eq("R4 no flag", ctl_rd_data, 32'd0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        chk_eq("R8 single pulse", {31'd0, out_valid}, 32'd0);
        chk_eq("R8 result held", out_result, 32'hFFFF_FFFF);
        chk_eq("R8 dest held", {27'd0, out_dest}, 32'd9);
    endtask

    task automatic t_sat();
        issue(enc(5'd5, 5'd6, 5'd11, 1'b1), 32'hFFF0_0005, 32'h0020_0007, 1'b1, 1'b0);
        chk_eq("R3 sat high", out_result, 32'hFFFF_000C);
        chk_eq("R4 flag sat", ctl_rd_data, 32'h0010_0000);
        clear_flag();
        issue(enc(5'd5, 5'd6, 5'd12, 1'b1), 32'h0001_FFFF, 32'h0002_FFFF, 1'b1, 1'b0);
        chk_eq("R3 sat low", out_result, 32'h0003_FFFF);
        issue(enc(5'd5, 5'd6, 5'd12, 1'b1), 32'h1000_2000, 32'h0FFF_1FFF, 1'b1, 1'b0);
        chk_eq("R3 exact", out_result, 32'h1FFF_3FFF);
    endtask

    task automatic t_sticky();
        chk_eq("R5 held over clean add", ctl_rd_data, 32'h0010_0000);
        clear_flag();
        chk_eq("R5 cleared", ctl_rd_data, 32'd0);
        issue(enc(5'd1, 5'd1, 5'd1, 1'b0), 32'h0000_8000, 32'h0000_8000, 1'b1, 1'b1);
        chk_eq("R5 set beats clear", ctl_rd_data, 32'h0010_0000);
        issue(enc(5'd1, 5'd1, 5'd1, 1'b0), 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b1);
        chk_eq("R5 clear with clean add", ctl_rd_data, 32'd0);
    endtask

    task automatic t_reserved();
        logic [31:0] w;
        issue(enc(5'd2, 5'd2, 5'd4, 1'b0), 32'h0000_FFFF, 32'h0000_0001, 1'b1, 1'b0);
        w = enc(5'd2, 5'd2, 5'd8, 1'b0) ^ 32'h0000_0001;
        issue(w, 32'h1111_1111, 32'h1111_1111, 1'b1, 1'b0);
        chk_eq("R6 exc_reserved", {31'd0, exc_reserved}, 32'd1);
        chk_eq("R6 no valid", {31'd0, out_valid}, 32'd0);
        chk_eq("R6 result held", out_result, 32'h0000_0000);
        chk_eq("R6 dest held", {27'd0, out_dest}, 32'd4);
        chk_eq("R6 ctl unchanged", ctl_rd_data, 32'h0010_0000);
        w = enc(5'd2, 5'd2, 5'd8, 1'b0) ^ 32'h0000_0100;
        issue(w, 32'h1111_1111, 32'h1111_1111, 1'b1, 1'b0);
        chk_eq("R1 minor mismatch", {31'd0, exc_reserved}, 32'd1);
        w = enc(5'd2, 5'd2, 5'd8, 1'b0) ^ 32'h0400_0000;
        issue(w, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
        chk_eq("R1 major mismatch", {31'd0, exc_reserved}, 32'd1);
        chk_eq("R5 clear during fault", ctl_rd_data, 32'd0);
    endtask

    task automatic t_disabled();
        issue(enc(5'd2, 5'd2, 5'd15, 1'b0), 32'hFFFF_FFFF, 32'h0001_0001, 1'b0, 1'b0);
        chk_eq("R7 exc_disabled", {31'd0, exc_disabled}, 32'd1);
        chk_eq("R7 no valid", {31'd0, out_valid}, 32'd0);
        chk_eq("R7 no flag", ctl_rd_data, 32'd0);
        chk_eq("R7 dest held", {27'd0, out_dest}, 32'd4);
        issue(enc(5'd2, 5'd2, 5'd15, 1'b0) ^ 32'h0000_0004, 32'd0, 32'd0, 1'b0, 1'b0);
        chk_eq("R7 reserved priority", {30'd0, exc_reserved, exc_disabled}, 32'd2);
    endtask

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_word   = '0;
        src_s     = '0;
        src_t     = '0;
        dsp_en    = 1'b1;
        ctl_clear = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_selects();
        t_wrap();
        t_latency();
        t_sat();
        t_sticky();
        t_reserved();
        t_disabled();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule